// File: doc/BRIEF.md
# Asymmetric Channel and Rank Address Interleaver

This block turns a system physical byte address into a memory channel, a rank within that channel and a byte offset inside that rank. It is built for a memory system of four channels. Each channel carries three dual-rank modules, and one of those modules is smaller than the other two. Consecutive 64-byte lines go round-robin over the channels. Within a channel, lines first rotate over all six ranks. Once the smaller module's ranks are full, a second address region rotates over only the four ranks of the larger modules.

Requests arrive with a valid strobe, one per cycle if needed. Each result appears two cycles later with its own valid bit. An address beyond the installed capacity raises an out-of-range flag, and the other fields read zero. The capacities are parameters, so a simulation can use a tiny configuration with the same mapping. Division by six uses a constant reciprocal multiply rather than a divider.

Top module: `chan_rank_interleaver`

## Requirements
- R1: The low 6 address bits appear unchanged as out_off[5:0]. The bits above them in out_off hold the line number inside the selected rank.
- R2: With line index L = addr >> 6, out_chan = L mod 4. Lines 0..3 go to channels 0..3, and line 4 returns to channel 0.
- R3: With per-channel index I = L >> 2 and I < 6*SMALL_RANK_LINES, out_rank = I mod 6 and the in-rank line = I / 6.
- R4: With I >= 6*SMALL_RANK_LINES and J = I - 6*SMALL_RANK_LINES, out_rank = J mod 4 (ranks 0..3 only) and the in-rank line = SMALL_RANK_LINES + J / 4.
- R5: When L >= 4*(2*SMALL_RANK_LINES + 4*BIG_RANK_LINES), out_oor is 1 and out_chan, out_rank and out_off are all 0. Otherwise out_oor is 0.
- R6: Each accepted request yields exactly one result with out_valid high two clock cycles later. Requests may arrive on every cycle, and a cycle without in_valid yields out_valid low two cycles later.
- R7: While rst_n is low, and until a request has moved through the pipeline, out_valid and out_oor are 0.
- R8: No two in-range lines map to the same (channel, rank, in-rank line). Every in-range line maps to a distinct slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| in_addr | input | ADDR_W | System physical byte address |
| out_valid | output | 1 | Result strobe, two cycles after in_valid |
| out_chan | output | CH_LOG2 | Target channel |
| out_rank | output | 3 | Rank within the channel, 0..5 |
| out_off | output | RANK_LINE_W+6 | Byte offset inside the rank |
| out_oor | output | 1 | Address beyond installed capacity |

## Verification
The bench first sweeps every line of a small configuration back to back, from line 0 up to the top of the address space, with a varying byte offset. This pass covers the six-way region, the four-way region and the out-of-range area. A bijection test on the results separates a correct mapping from one that folds two lines onto the same slot. A second pass adds idle cycles between requests, which shows whether valid bits are delayed and matched to the right data. Chosen lines then test the channel wrap, the region boundary, the last in-range line and the first out-of-range line on their own.

// File: rtl/chan_rank_interleaver.sv
module chan_rank_interleaver #(
  parameter int ADDR_W = 38,
  parameter int CH_LOG2 = 2,
  parameter longint unsigned SMALL_RANK_LINES = 64'd67108864,
  parameter longint unsigned BIG_RANK_LINES = 64'd134217728,
  parameter int RANK_LINE_W = $clog2(BIG_RANK_LINES)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [ADDR_W-1:0]        in_addr,
  output logic                     out_valid,
  output logic [CH_LOG2-1:0]       out_chan,
  output logic [2:0]               out_rank,
  output logic [RANK_LINE_W+5:0]   out_off,
  output logic                     out_oor
);
  localparam int LINE_W = 6;
  localparam int IDX_W = ADDR_W - LINE_W - CH_LOG2;
  localparam int SH = IDX_W + 3;
  localparam int PW = 2 * IDX_W + 4;
  localparam longint unsigned REG1_LINES = 6 * SMALL_RANK_LINES;
  localparam longint unsigned CH_LINES = 2 * SMALL_RANK_LINES + 4 * BIG_RANK_LINES;
  localparam longint unsigned SYS_LINES = CH_LINES << CH_LOG2;
  localparam logic [IDX_W+3:0] POW = (IDX_W+4)'(1) << SH;
  localparam logic [IDX_W+3:0] MUL = (POW + (IDX_W+4)'(5)) / (IDX_W+4)'(6);

  wire [ADDR_W-LINE_W-1:0] line_a = in_addr[ADDR_W-1:LINE_W];
  wire [IDX_W-1:0]         idx_a  = in_addr[ADDR_W-1:LINE_W+CH_LOG2];
  wire                     oor_a  = 64'(line_a) >= SYS_LINES;
  wire                     reg2_a = 64'(idx_a) >= REG1_LINES;
  wire [IDX_W-1:0]         idx2_a = idx_a - IDX_W'(REG1_LINES);

  logic               s1_v, s1_oor, s1_reg2;
  logic [CH_LOG2-1:0] s1_ch;
  logic [LINE_W-1:0]  s1_byte;
  logic [IDX_W-1:0]   s1_idx;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) s1_v <= 1'b0;
    else        s1_v <= in_valid;

  always_ff @(posedge clk) begin
    s1_oor  <= oor_a;
    s1_reg2 <= reg2_a;
    s1_ch   <= in_addr[LINE_W+CH_LOG2-1:LINE_W];
    s1_byte <= in_addr[LINE_W-1:0];
    s1_idx  <= reg2_a ? idx2_a : idx_a;
  end

  wire [PW-1:0]    prod  = PW'(s1_idx) * PW'(MUL);
  wire [IDX_W-1:0] q6    = prod[SH +: IDX_W];
  wire [IDX_W-1:0] r6    = s1_idx - (q6 << 2) - (q6 << 1);
  wire [IDX_W-1:0] line2 = IDX_W'(SMALL_RANK_LINES) + (s1_idx >> 2);
  wire [IDX_W-1:0] rline = s1_reg2 ? line2 : q6;
  wire [2:0]       rank  = s1_reg2 ? {1'b0, s1_idx[1:0]} : r6[2:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_oor   <= 1'b0;
    end else begin
      out_valid <= s1_v;
      out_oor   <= s1_v & s1_oor;
    end

  always_ff @(posedge clk) begin
    out_chan <= s1_oor ? '0 : s1_ch;
    out_rank <= s1_oor ? '0 : rank;
    out_off  <= s1_oor ? '0 : {rline[RANK_LINE_W-1:0], s1_byte};
  end
endmodule

// File: rtl/chan_rank_interleaver_chk.sv
module chan_rank_interleaver_chk #(
  parameter int ADDR_W = 38,
  parameter int CH_LOG2 = 2,
  parameter longint unsigned SMALL_RANK_LINES = 64'd67108864,
  parameter int RANK_LINE_W = 27
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic [ADDR_W-1:0]      in_addr,
  input logic                   out_valid,
  input logic [CH_LOG2-1:0]     out_chan,
  input logic [2:0]             out_rank,
  input logic [RANK_LINE_W+5:0] out_off,
  input logic                   out_oor
);
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) age <= 2'd0;
    else if (age != 2'd2) age <= age + 2'd1;

  assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    age == 2'd2 |-> out_valid == $past(in_valid, 2));
  assert_chan_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd2 && out_valid && !out_oor) |-> out_chan == $past(in_addr[CH_LOG2+5:6], 2));
  assert_byte_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd2 && out_valid && !out_oor) |-> out_off[5:0] == $past(in_addr[5:0], 2));
  assert_oor_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_oor) |-> (out_chan == '0 && out_rank == '0 && out_off == '0));
  assert_rank_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_rank < 3'd6);
  assert_region2_ranks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_oor && 64'(out_off[RANK_LINE_W+5:6]) >= SMALL_RANK_LINES) |-> out_rank < 3'd4);
  assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !out_oor);
endmodule

bind chan_rank_interleaver chan_rank_interleaver_chk #(
  .ADDR_W(ADDR_W), .CH_LOG2(CH_LOG2),
  .SMALL_RANK_LINES(SMALL_RANK_LINES), .RANK_LINE_W(RANK_LINE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
  .out_valid(out_valid), .out_chan(out_chan), .out_rank(out_rank),
  .out_off(out_off), .out_oor(out_oor)
);

// File: tb/chan_rank_interleaver_test.sv
module chan_rank_interleaver_test;
  localparam int AW = 14;
  localparam int S = 4;
  localparam int B = 8;
  localparam int RW = 3;
  localparam int SYS = 4 * (2 * S + 4 * B);

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid;
  logic [AW-1:0] in_addr;
  logic out_valid, out_oor;
  logic [1:0] out_chan;
  logic [2:0] out_rank;
  logic [RW+5:0] out_off;

  always #10 clk = ~clk;

  chan_rank_interleaver #(
    .ADDR_W(AW), .CH_LOG2(2),
    .SMALL_RANK_LINES(64'(S)), .BIG_RANK_LINES(64'(B)), .RANK_LINE_W(RW)
  ) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
    .out_valid(out_valid), .out_chan(out_chan), .out_rank(out_rank),
    .out_off(out_off), .out_oor(out_oor)
  );

  int checks = 0;
  int fails = 0;
  int n = 0;
  bit marking = 0;
  bit done = 0;
  logic [AW-1:0] h_addr [0:2047];
  logic          h_v    [0:2047];
  int seen [0:191];

  task automatic chk(input string req, input bit ok, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic verify(input int k);
    int L, ch, idx, j, rk, rl, exp_off;
    bit oor;
    string rq;
    if (!h_v[k]) begin
      chk("R6 idle", out_valid == 1'b0, out_valid, 0);
      return;
    end
    chk("R6 valid", out_valid == 1'b1, out_valid, 1);
    L = int'(h_addr[k] >> 6);
    oor = L >= SYS;
    ch = L % 4; idx = L / 4;
    if (idx < 6 * S) begin rk = idx % 6; rl = idx / 6; rq = "R3"; end
    else begin j = idx - 6 * S; rk = j % 4; rl = S + j / 4; rq = "R4"; end
    chk("R5 flag", out_oor == oor, out_oor, oor);
    if (oor) begin
      chk("R5 zero", out_chan == 0 && out_rank == 0 && out_off == 0, out_off, 0);
      return;
    end
    exp_off = rl * 64 + int'(h_addr[k][5:0]);
    chk("R2 chan", out_chan == ch, out_chan, ch);
    chk({rq, " rank"}, out_rank == rk, out_rank, rk);
    chk("R1 low", out_off[5:0] == h_addr[k][5:0], out_off[5:0], h_addr[k][5:0]);
    chk({rq, " line"}, out_off == exp_off, out_off, exp_off);
    if (marking && out_rank < 6) seen[out_chan * 48 + out_rank * 8 + out_off[RW+5:6]]++;
  endtask

  task automatic drive(input bit v, input int line, input int byt);
    @(negedge clk);
    if (n >= 2) verify(n - 2);
    h_v[n] = v;
    h_addr[n] = AW'(line * 64 + byt);
    in_valid = v;
    in_addr = AW'(line * 64 + byt);
    n++;
  endtask

  initial begin
    for (int i = 0; i < 192; i++) seen[i] = 0;
    rst_n = 1'b0; in_valid = 1'b0; in_addr = '0;
    repeat (3) @(negedge clk);
    chk("R7 reset valid", out_valid == 1'b0, out_valid, 0);
    chk("R7 reset oor", out_oor == 1'b0, out_oor, 0);
    rst_n = 1'b1;
    marking = 1;
    for (int L = 0; L < 256; L++) drive(1, L, (L * 37 + 5) & 63);
    drive(0, 0, 0); drive(0, 0, 0);
    @(negedge clk); verify(n - 2); n++;
    marking = 0;
    // R8: every in-range slot hit exactly once
    begin
      int hit = 0, dup = 0;
      for (int i = 0; i < 192; i++) begin
        if (seen[i] != 0) hit++;
        if (seen[i] > 1) dup++;
      end
      chk("R8 duplicates", dup == 0, dup, 0);
      chk("R8 coverage", hit == SYS, hit, SYS);
    end
    h_v[n-1] = 0; h_v[n-2] = 0;
    // R6 bubbles
    for (int k = 0; k < 60; k++) drive(k % 3 != 0, (k * 11) % 256, k & 63);
    // named corners: wrap (R2), region boundary (R4), last in range, first out (R5)
    drive(1, 3, 63); drive(1, 4, 0); drive(1, 95, 1); drive(1, 96, 2);
    drive(1, 159, 63); drive(1, 160, 0); drive(1, 255, 63); drive(1, 0, 0);
    drive(0, 0, 0); drive(0, 0, 0); drive(0, 0, 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule